// File: doc/BRIEF.md
# Two-Level Inclusive Cache Controller

This block sits between a processor's load/store port and a main-memory port. It keeps a small direct-mapped first-level data cache and a larger direct-mapped second-level cache. A load is looked up in the first level, then the second level, and then memory. On the way back it fills every level that missed. The controller handles one request at a time. It accepts a new request only while it is idle.

Stores follow a per-request policy picked by `wb_mode`:

- **Write-through** (`wb_mode`=0) updates both cache levels and memory before the request completes.
- **Write-back** (`wb_mode`=1) writes only the first level and marks it dirty. Dirty data moves down one level when its block is evicted.

A store miss allocates the block at both levels before writing it. A block is one data word, so one transfer moves a whole block. Every valid first-level block is always also held by the second level. When a second-level block is evicted, any first-level copy is invalidated, and dirty first-level data is merged into the write to memory.

Top module: `l2_incl_cache_ctrl`

## Requirements

**Timing convention.** Latency is counted in clock edges. It starts from the edge that accepts the request and ends with `resp_valid` high.

**Address decoding.** Addresses are word addresses. The first-level set is `addr[1:0]` and the second-level set is `addr[3:0]` (default parameters).

- R1: A load that hits in the first level responds 2 cycles after acceptance, with no memory request.
- R2: A load that misses the first level but hits the second level responds 4 cycles after acceptance with no memory request. A repeat load of the same address then responds in 2 cycles.
- R3: A load that misses both levels issues exactly one memory read of its address and returns the memory word.
- R4: A write-through store causes exactly one memory write of its address and data before `resp_valid`. Later loads return the stored data.
- R5: A write-back store writes no memory. When its dirty block leaves the first level, it is written into the second level without memory traffic. When the dirty block leaves the second level, its data is written to memory.
- R6: Every valid first-level block is present, valid and with a matching address, in the second level at all times.
- R7: When the second level evicts a block whose first-level copy is dirty, the first-level data is the word written to memory, and that first-level copy is invalidated.
- R8: A store miss reads the block from memory, then places the store data in the first level, so that an immediate load of it hits in 2 cycles.
- R9: `mem_req`, `mem_we` and `mem_addr` stay stable from the rise of `mem_req` until the cycle of `mem_ack`.
- R10: After reset both levels are empty, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R11: `req_ready` is 1 only while idle, so `resp_valid` and `req_ready` are never high together.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | Store policy, sampled at acceptance: 1 write-back, 0 write-through |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 store, 0 load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| resp_valid | output | 1 | Request complete (one cycle) |
| resp_rdata | output | DW | Load data, valid with resp_valid |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 memory write, 0 memory read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory transfer done; read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification

The assertions assume the following about the memory side:

- `mem_ack` arrives only while `mem_req` is high and lasts one cycle.
- `wb_mode` matters only at acceptance.

The bench memory model keeps to this. It acknowledges after a random wait of zero to two cycles, and it drops `mem_ack` in the cycle after each acknowledge. The bench drives a request only while `req_ready` is high, and releases `req_valid` right after acceptance. Random addresses are confined to 64 words, so that set conflicts and write-back evictions at both levels occur often.

// File: rtl/l2_incl_cache_ctrl.sv
module l2_incl_cache_ctrl #(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int L1_SETS = 4,
  parameter int L2_SETS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_mode,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int L1_IW = $clog2(L1_SETS);
  localparam int L2_IW = $clog2(L2_SETS);
  localparam int L1_TW = AW - L1_IW;
  localparam int L2_TW = AW - L2_IW;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_LOOKUP, ST_L2_LOOKUP, ST_L2_EVICT,
    ST_MEM_FILL, ST_L1_EVICT, ST_L1_FILL, ST_RESPOND
  } state_t;

  state_t state;

  logic [AW-1:0] addr_q, ev_addr;
  logic [DW-1:0] wdata_q, rdata_q, ev_data;
  logic          we_q, wb_q;

  logic [L1_SETS-1:0]            l1_val, l1_dty;
  logic [L1_SETS-1:0][L1_TW-1:0] l1_tag;
  logic [L1_SETS-1:0][DW-1:0]    l1_dat;
  logic [L2_SETS-1:0]            l2_val, l2_dty;
  logic [L2_SETS-1:0][L2_TW-1:0] l2_tag;
  logic [L2_SETS-1:0][DW-1:0]    l2_dat;

  logic [L1_IW-1:0] l1_i;
  logic [L2_IW-1:0] l2_i, l1v_l2i;
  logic [L1_TW-1:0] l1_t;
  logic [L2_TW-1:0] l2_t;
  logic [AW-1:0]    l1v_addr, l2v_addr;
  logic             l1_hit, l2_hit, l1v_dirty, l1_has_l2v, l1_merge, ev_dirty, wt_store;

  assign l1_i       = addr_q[L1_IW-1:0];
  assign l2_i       = addr_q[L2_IW-1:0];
  assign l1_t       = addr_q[AW-1:L1_IW];
  assign l2_t       = addr_q[AW-1:L2_IW];
  assign l1_hit     = l1_val[l1_i] && (l1_tag[l1_i] == l1_t);
  assign l2_hit     = l2_val[l2_i] && (l2_tag[l2_i] == l2_t);
  assign l1v_addr   = {l1_tag[l1_i], l1_i};
  assign l2v_addr   = {l2_tag[l2_i], l2_i};
  assign l1v_l2i    = l1v_addr[L2_IW-1:0];
  assign l1v_dirty  = l1_val[l1_i] && l1_dty[l1_i];
  assign l1_has_l2v = l1_val[l1_i] && (l1v_addr == l2v_addr);
  assign l1_merge   = l1_has_l2v && l1_dty[l1_i];
  assign ev_dirty   = l2_dty[l2_i] || l1_merge;
  assign wt_store   = we_q && !wb_q;

  assign req_ready  = (state == ST_IDLE);
  assign resp_valid = (state == ST_RESPOND) && (!wt_store || mem_ack);
  assign resp_rdata = rdata_q;
  assign mem_req    = (state == ST_L2_EVICT) || (state == ST_MEM_FILL) ||
                      ((state == ST_RESPOND) && wt_store);
  assign mem_we     = (state != ST_MEM_FILL);
  assign mem_addr   = (state == ST_L2_EVICT) ? ev_addr : addr_q;
  assign mem_wdata  = (state == ST_L2_EVICT) ? ev_data : wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ev_addr <= '0;
      ev_data <= '0;
      we_q    <= 1'b0;
      wb_q    <= 1'b0;
      l1_val  <= '0;
      l1_dty  <= '0;
      l1_tag  <= '0;
      l1_dat  <= '0;
      l2_val  <= '0;
      l2_dty  <= '0;
      l2_tag  <= '0;
      l2_dat  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          we_q    <= req_we;
          wb_q    <= wb_mode;
          state   <= ST_L1_LOOKUP;
        end
        ST_L1_LOOKUP: if (l1_hit) begin
          if (!we_q) rdata_q <= l1_dat[l1_i];
          else begin
            l1_dat[l1_i] <= wdata_q;
            if (wb_q) l1_dty[l1_i] <= 1'b1;
            else      l2_dat[l2_i] <= wdata_q;
          end
          state <= ST_RESPOND;
        end else begin
          state <= ST_L2_LOOKUP;
        end
        ST_L2_LOOKUP: if (l2_hit) begin
          state <= l1v_dirty ? ST_L1_EVICT : ST_L1_FILL;
        end else begin
          ev_addr <= l2v_addr;
          ev_data <= l1_merge ? l1_dat[l1_i] : l2_dat[l2_i];
          if (l1_has_l2v) begin
            l1_val[l1_i] <= 1'b0;
            l1_dty[l1_i] <= 1'b0;
          end
          state <= (l2_val[l2_i] && ev_dirty) ? ST_L2_EVICT : ST_MEM_FILL;
        end
        ST_L2_EVICT: if (mem_ack) state <= ST_MEM_FILL;
        ST_MEM_FILL: if (mem_ack) begin
          l2_val[l2_i] <= 1'b1;
          l2_dty[l2_i] <= 1'b0;
          l2_tag[l2_i] <= l2_t;
          l2_dat[l2_i] <= mem_rdata;
          state        <= l1v_dirty ? ST_L1_EVICT : ST_L1_FILL;
        end
        ST_L1_EVICT: begin
          l2_dat[l1v_l2i] <= l1_dat[l1_i];
          l2_dty[l1v_l2i] <= 1'b1;
          l1_dty[l1_i]    <= 1'b0;
          state           <= ST_L1_FILL;
        end
        ST_L1_FILL: begin
          l1_val[l1_i] <= 1'b1;
          l1_tag[l1_i] <= l1_t;
          rdata_q      <= l2_dat[l2_i];
          if (!we_q) begin
            l1_dat[l1_i] <= l2_dat[l2_i];
            l1_dty[l1_i] <= 1'b0;
          end else begin
            l1_dat[l1_i] <= wdata_q;
            l1_dty[l1_i] <= wb_q;
            if (!wb_q) l2_dat[l2_i] <= wdata_q;
          end
          state <= ST_RESPOND;
        end
        ST_RESPOND: if (!wt_store || mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2_incl_cache_ctrl_chk.sv
module l2_incl_cache_ctrl_chk #(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int L1_SETS = 4,
  parameter int L2_SETS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_lookup,
  input logic in_respond,
  input logic l1_hit,
  input logic we_q,
  input logic wb_q,
  input logic req_ready,
  input logic resp_valid,
  input logic mem_req,
  input logic mem_we,
  input logic mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [L1_SETS-1:0] l1_val,
  input logic [L1_SETS-1:0][AW-$clog2(L1_SETS)-1:0] l1_tag,
  input logic [L2_SETS-1:0] l2_val,
  input logic [L2_SETS-1:0][AW-$clog2(L2_SETS)-1:0] l2_tag
);
  localparam int L1_IW = $clog2(L1_SETS);
  localparam int L2_IW = $clog2(L2_SETS);

  AST_L1_READ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup && l1_hit && !we_q |=> in_respond) else $error("AST_L1_READ_HIT"); // R1

  AST_WT_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && we_q && !wb_q |-> mem_req && mem_we && mem_ack) else $error("AST_WT_MEM_FIRST"); // R4

  AST_WB_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup && l1_hit && we_q && wb_q |=> !mem_req) else $error("AST_WB_STORE_QUIET"); // R5

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)) else $error("AST_MEM_HOLD"); // R9

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready) else $error("AST_ONE_AT_A_TIME"); // R11

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < L1_SETS; i++) begin
        logic [AW-1:0] a;
        a = {l1_tag[i], i[L1_IW-1:0]};
        AST_INCLUSION: assert (!l1_val[i] ||
          (l2_val[a[L2_IW-1:0]] && l2_tag[a[L2_IW-1:0]] == a[AW-1:L2_IW]))
          else $error("AST_INCLUSION set %0d", i); // R6
      end
    end
  end
endmodule

bind l2_incl_cache_ctrl l2_incl_cache_ctrl_chk #(
  .DW(DW), .AW(AW), .L1_SETS(L1_SETS), .L2_SETS(L2_SETS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_lookup(state == ST_L1_LOOKUP), .in_respond(state == ST_RESPOND),
  .l1_hit(l1_hit), .we_q(we_q), .wb_q(wb_q),
  .req_ready(req_ready), .resp_valid(resp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .l1_val(l1_val), .l1_tag(l1_tag), .l2_val(l2_val), .l2_tag(l2_tag)
);

// File: tb/l2_incl_cache_ctrl_tb.sv
module l2_incl_cache_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wb_mode = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, mem_req, mem_we;
  logic [DW-1:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  l2_incl_cache_ctrl #(.DW(DW), .AW(AW), .L1_SETS(4), .L2_SETS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [DW-1:0] mem_model [NW];
  logic [DW-1:0] arch [NW];
  int n_rd = 0, n_wr = 0, wait_cnt = 0;
  int checks = 0, errors = 0;

  function automatic logic [DW-1:0] init_word(input int a);
    return {a[7:0], a[7:0] ^ 8'h5A};
  endfunction

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin mem_model[mem_addr] <= mem_wdata; n_wr <= n_wr + 1; end
        else begin mem_rdata <= mem_model[mem_addr]; n_rd <= n_rd + 1; end
        wait_cnt <= int'($urandom % 3);
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int lat;
  logic [DW-1:0] rd;
  int rd0, wr0;

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic wb);
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    wb_mode = wb; req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin @(negedge clk); lat++; end
    rd = resp_rdata;
    if (we) arch[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    for (int i = 0; i < NW; i++) begin mem_model[i] = init_word(i); arch[i] = init_word(i); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready", 32'(req_ready), 1);
    chk("R10 resp", 32'(resp_valid), 0);
    chk("R10 memreq", 32'(mem_req), 0);
    rst_n = 1'b1;

    do_op(0, 8'h05, 0, 0);
    chk("R3 data", 32'(rd), 32'(init_word(5)));
    chk("R3 one read", 32'(n_rd - rd0), 1);
    do_op(0, 8'h05, 0, 0);
    chk("R1 latency", 32'(lat), 2);
    chk("R1 no mem", 32'(n_rd - rd0 + n_wr - wr0), 0);
    do_op(0, 8'h09, 0, 0);
    chk("R3 data 9", 32'(rd), 32'(init_word(9)));
    do_op(0, 8'h05, 0, 0);
    chk("R2 latency", 32'(lat), 4);
    chk("R2 no mem", 32'(n_rd - rd0 + n_wr - wr0), 0);
    chk("R2 data", 32'(rd), 32'(init_word(5)));
    do_op(0, 8'h05, 0, 0);
    chk("R2 refill hit", 32'(lat), 2);
    do_op(1, 8'h05, 16'hBEEF, 0);
    chk("R4 one write", 32'(n_wr - wr0), 1);
    chk("R4 mem data", 32'(mem_model[5]), 32'hBEEF);
    do_op(1, 8'h05, 16'h1234, 1);
    chk("R5 no write", 32'(n_wr - wr0), 0);
    chk("R5 mem kept", 32'(mem_model[5]), 32'hBEEF);
    do_op(0, 8'h09, 0, 1);
    chk("R5 L1 evict quiet", 32'(n_wr - wr0), 0);
    chk("R5 data 9", 32'(rd), 32'(init_word(9)));
    do_op(0, 8'h15, 0, 1);
    chk("R5 L2 evict write", 32'(n_wr - wr0), 1);
    chk("R5 L2 evict data", 32'(mem_model[5]), 32'h1234);
    do_op(1, 8'h25, 16'hCAFE, 1);
    chk("R8 fetch", 32'(n_rd - rd0), 1);
    chk("R8 no write", 32'(n_wr - wr0), 0);
    do_op(0, 8'h25, 0, 1);
    chk("R8 hit latency", 32'(lat), 2);
    chk("R8 data", 32'(rd), 32'hCAFE);
    do_op(0, 8'h35, 0, 1);
    chk("R7 merged write", 32'(n_wr - wr0), 1);
    chk("R7 merged data", 32'(mem_model[8'h25]), 32'hCAFE);
    do_op(0, 8'h25, 0, 1);
    chk("R7 reload", 32'(rd), 32'hCAFE);

    for (int k = 0; k < 400; k++) begin
      logic we, wb;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      we = ($urandom % 10) < 4;
      wb = ((k / 50) % 2) == 1;
      a  = AW'($urandom % 64);
      d  = DW'($urandom);
      do_op(we, a, d, wb);
      if (!we) chk("R3 random load", 32'(rd), 32'(arch[a]));
      else if (!wb) chk("R4 random wt store", 32'(mem_model[a]), 32'(d));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule